// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Escalating Reset

This block is a watchdog for a processor subsystem. A nine-bit counter, made of an eight-bit magnitude and a sign bit, counts down once for every slow tick the surrounding clock logic supplies. Software reloads it regularly. When software stops reloading it, the count drops below zero and the block reacts in one of two ways. In reset mode it pulses its reset output at once. In interrupt mode it raises a non-maskable interrupt. The counter then keeps running into negative values. If automatic escalation is enabled and the interrupt handler also fails to reload, the block pulses its reset output when the count reaches minus sixteen.

Counting pauses whenever the debug-halt input is high, and software cannot mask this. Software can also request a freeze of its own through set and clear strobes. That request takes effect only while a permission bit in the configuration allows it. A reset pulse lasts a fixed number of system clocks. After the pulse, the counter is back at its full value and the interrupt is clear.

Top module: `wdg_sign_timer`

## Requirements
- R1: After synchronous reset, `nmi_o` and `wrst_o` are low. The configuration is interrupt mode with escalation enabled and software freeze allowed. The count is 255, so the 256th unfrozen tick raises `nmi_o` and the first 255 do not.
- R2: A reload with value V makes `nmi_o` rise on the (V+1)-th unfrozen tick after the reload, in interrupt mode. This is the step from 0 to -1. `nmi_o` is high in the cycle after the clock edge that takes that tick. It stays high until the next reload.
- R3: In interrupt mode with escalation enabled (`cfg_auto_rst`=1), `wrst_o` rises on the 15th unfrozen tick after the tick that raised `nmi_o`, when the count would pass -15. With escalation disabled, `wrst_o` never rises in interrupt mode, and the count stops at -256.
- R4: In reset mode (`cfg_rst_mode`=1), the tick that would take the count from 0 to -1 raises `wrst_o` instead, and `nmi_o` does not rise.
- R5: `wrst_o` stays high for exactly 4 clock cycles and then falls. The same edge that raises it reloads the count to 255 and clears `nmi_o`.
- R6: While `dbg_halt` is high, ticks have no effect on the count, whatever the configuration.
- R7: After a `frz_set` strobe and before a `frz_clr` strobe, ticks have no effect, but only while `cfg_frz_allow`=1. With `cfg_frz_allow`=0, ticks count normally. The freeze request itself is kept, so the freeze applies again once the permission bit returns to 1. If both strobes arrive together, the clear wins.
- R8: A reload clears `nmi_o` in the next cycle and sets the count to the written value. A tick arriving in the same cycle as a reload is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle slow tick strobe that advances the count |
| reload_we | input | 1 | Reload strobe |
| reload_val | input | 8 | Value loaded into the count on reload |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rst_mode | input | 1 | 1 = reset on expiry, 0 = interrupt on expiry |
| cfg_auto_rst | input | 1 | Escalate an unserviced interrupt to reset |
| cfg_frz_allow | input | 1 | Permits the software freeze to take effect |
| frz_set | input | 1 | Software freeze request strobe |
| frz_clr | input | 1 | Software unfreeze strobe |
| dbg_halt | input | 1 | Processor halted in debug state; freezes counting |
| nmi_o | output | 1 | Non-maskable interrupt, held until reload |
| wrst_o | output | 1 | Watchdog reset pulse |

## Verification
The assertions assume the strobe inputs are single-cycle pulses sampled on the clock edge. They also assume that a reset pulse is not retriggered while one is still running. A retrigger would restart the hold window, and the simple stretch check does not cover that case. The stimulus keeps within these assumptions. The directed phase issues reloads, config writes and freeze strobes one per cycle and lets each reset pulse finish. The random phase uses rare strobes and mostly small reload values, so expiry, escalation and freezes all occur often. A bench reference model predicts both outputs on every cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef struct packed {
    logic rst_mode;
    logic auto_rst;
    logic frz_allow;
  } wdg_cfg_t;

  localparam wdg_cfg_t WDG_CFG_RESET = '{rst_mode: 1'b0, auto_rst: 1'b1, frz_allow: 1'b1};

endpackage

// File: rtl/wdg_ctl_regs.sv
module wdg_ctl_regs
  import wdg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cfg_we,
  input  wdg_cfg_t cfg_in,
  input  logic     frz_set,
  input  logic     frz_clr,
  input  logic     dbg_halt,
  input  logic     tick_en,
  output wdg_cfg_t cfg_q,
  output logic     step
);

  logic sw_frz_q;
  logic frozen;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= WDG_CFG_RESET;
    end else if (cfg_we) begin
      cfg_q <= cfg_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_frz_q <= 1'b0;
    end else if (frz_clr) begin
      sw_frz_q <= 1'b0;
    end else if (frz_set) begin
      sw_frz_q <= 1'b1;
    end
  end

  always_comb begin
    frozen = dbg_halt | (sw_frz_q & cfg_q.frz_allow);
    step   = tick_en & ~frozen;
  end

  // R7
  frz_clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    frz_clr |=> !sw_frz_q);

  // R7
  frz_set_chk: assert property (@(posedge clk) disable iff (rst)
    (frz_set && !frz_clr) |=> sw_frz_q);

endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
  parameter int              CNT_W      = 8,
  parameter int              ESC_DEPTH  = 16,
  parameter logic [CNT_W-1:0] LOAD_VAL  = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             reload_we,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             rst_mode,
  input  logic             auto_rst,
  input  logic             restart,
  output logic             nmi_q,
  output logic             fire
);

  localparam int CW    = CNT_W + 1;
  localparam int ESC_I = -(ESC_DEPTH - 1);
  localparam logic [CW-1:0] ZERO_V  = '0;
  localparam logic [CW-1:0] ESC_V   = ESC_I[CW-1:0];
  localparam logic [CW-1:0] MIN_V   = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CW-1:0] FULL_V  = {1'b0, LOAD_VAL};

  logic [CW-1:0] cnt_q;
  logic          adv;
  logic          at_zero;
  logic          at_esc;

  always_comb begin
    adv     = step & ~reload_we;
    at_zero = (cnt_q == ZERO_V);
    at_esc  = (cnt_q == ESC_V);
    fire    = adv & ((rst_mode & at_zero) | (~rst_mode & auto_rst & at_esc));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= FULL_V;
      nmi_q <= 1'b0;
    end else if (reload_we) begin
      cnt_q <= {1'b0, reload_val};
      nmi_q <= 1'b0;
    end else if (restart) begin
      cnt_q <= FULL_V;
      nmi_q <= 1'b0;
    end else if (adv) begin
      if (!rst_mode && at_zero) begin
        nmi_q <= 1'b1;
      end
      if (cnt_q != MIN_V) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R8
  reload_clears_nmi_chk: assert property (@(posedge clk) disable iff (rst)
    reload_we |=> !nmi_q);

  // R8
  reload_loads_chk: assert property (@(posedge clk) disable iff (rst)
    reload_we |=> (cnt_q == {1'b0, $past(reload_val)}));

  // R6
  frozen_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !reload_we && !restart) |=> $stable(cnt_q));

  // R2
  nmi_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_q) |-> ($past(step) && !$past(rst_mode)));

  // R4
  no_nmi_reset_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (rst_mode && !nmi_q) |=> (!nmi_q || !$past(rst_mode)));

endmodule

// File: rtl/wdg_rst_stretch.sv
module wdg_rst_stretch #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic wrst_q
);

  localparam int HW = (HOLD > 2) ? $clog2(HOLD) : 1;
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD - 1);

  logic [HW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrst_q <= 1'b0;
      left_q <= '0;
    end else if (fire) begin
      wrst_q <= 1'b1;
      left_q <= HOLD_LAST;
    end else if (wrst_q) begin
      if (left_q == '0) begin
        wrst_q <= 1'b0;
      end else begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  // R5
  rst_starts_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> wrst_q);

  // R5
  rst_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (wrst_q && left_q != '0) |=> wrst_q);

  // R5
  rst_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (wrst_q && left_q == '0 && !fire) |=> !wrst_q);

endmodule

// File: rtl/wdg_sign_timer.sv
module wdg_sign_timer
  import wdg_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int ESC_DEPTH = 16,
  parameter int RST_HOLD  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             reload_we,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             cfg_we,
  input  logic             cfg_rst_mode,
  input  logic             cfg_auto_rst,
  input  logic             cfg_frz_allow,
  input  logic             frz_set,
  input  logic             frz_clr,
  input  logic             dbg_halt,
  output logic             nmi_o,
  output logic             wrst_o
);

  wdg_cfg_t cfg_in;
  wdg_cfg_t cfg_q;
  logic     step;
  logic     fire;

  always_comb begin
    cfg_in.rst_mode  = cfg_rst_mode;
    cfg_in.auto_rst  = cfg_auto_rst;
    cfg_in.frz_allow = cfg_frz_allow;
  end

  wdg_ctl_regs u_ctl (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_in   (cfg_in),
    .frz_set  (frz_set),
    .frz_clr  (frz_clr),
    .dbg_halt (dbg_halt),
    .tick_en  (tick_en),
    .cfg_q    (cfg_q),
    .step     (step)
  );

  wdg_count #(
    .CNT_W     (CNT_W),
    .ESC_DEPTH (ESC_DEPTH),
    .LOAD_VAL  ({CNT_W{1'b1}})
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .step       (step),
    .reload_we  (reload_we),
    .reload_val (reload_val),
    .rst_mode   (cfg_q.rst_mode),
    .auto_rst   (cfg_q.auto_rst),
    .restart    (fire),
    .nmi_q      (nmi_o),
    .fire       (fire)
  );

  wdg_rst_stretch #(
    .HOLD (RST_HOLD)
  ) u_rst (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire),
    .wrst_q (wrst_o)
  );

  // R6
  dbg_no_nmi_rise_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_halt |=> !$rose(nmi_o));

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (!nmi_o && !wrst_o));

endmodule

// File: tb/sim_wdg_sign_timer.sv
module sim_wdg_sign_timer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 0, reload_we = 0, cfg_we = 0;
  logic [7:0] reload_val = 0;
  logic       cfg_rst_mode = 0, cfg_auto_rst = 1, cfg_frz_allow = 1;
  logic       frz_set = 0, frz_clr = 0, dbg_halt = 0;
  logic       nmi_o, wrst_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #5 clk = ~clk;

  wdg_sign_timer u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .reload_we(reload_we),
    .reload_val(reload_val), .cfg_we(cfg_we), .cfg_rst_mode(cfg_rst_mode),
    .cfg_auto_rst(cfg_auto_rst), .cfg_frz_allow(cfg_frz_allow),
    .frz_set(frz_set), .frz_clr(frz_clr), .dbg_halt(dbg_halt),
    .nmi_o(nmi_o), .wrst_o(wrst_o)
  );

  // reference model built from the requirements
  int m_cnt;
  bit m_nmi, m_wrst, m_mrst, m_auto, m_allow, m_sfrz;
  int m_hold;

  function automatic bit model_fire(int c, bit mrst, bit aut);
    return (mrst && c == 0) || (!mrst && aut && c == -15);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 255; m_nmi = 0; m_wrst = 0; m_hold = 0;
      m_mrst = 0; m_auto = 1; m_allow = 1; m_sfrz = 0;
    end else begin
      bit frz, fire;
      frz = dbg_halt || (m_sfrz && m_allow);
      fire = 0;
      if (m_wrst) begin
        if (m_hold == 0) m_wrst = 0; else m_hold--;
      end
      if (reload_we) begin
        m_cnt = reload_val; m_nmi = 0;
      end else if (tick_en && !frz) begin
        if (model_fire(m_cnt, m_mrst, m_auto)) fire = 1;
        else begin
          if (m_cnt == 0 && !m_mrst) m_nmi = 1;
          if (m_cnt > -256) m_cnt--;
        end
      end
      if (fire) begin
        m_cnt = 255; m_nmi = 0; m_wrst = 1; m_hold = 3;
      end
      if (cfg_we) begin
        m_mrst = cfg_rst_mode; m_auto = cfg_auto_rst; m_allow = cfg_frz_allow;
      end
      if (frz_clr) m_sfrz = 0; else if (frz_set) m_sfrz = 1;
    end
  end

  task automatic check(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && cmp_on && !done) begin
      check(nmi_o, m_nmi, "R2 model nmi_o");
      check(wrst_o, m_wrst, "R5 model wrst_o");
    end
  end

  task automatic tick1();
    @(negedge clk) tick_en = 1;
    @(negedge clk) tick_en = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick1();
  endtask

  task automatic reload(input logic [7:0] v);
    @(negedge clk) begin reload_we = 1; reload_val = v; end
    @(negedge clk) reload_we = 0;
  endtask

  task automatic cfg(input bit mr, input bit au, input bit al);
    @(negedge clk) begin cfg_we = 1; cfg_rst_mode = mr; cfg_auto_rst = au; cfg_frz_allow = al; end
    @(negedge clk) cfg_we = 0;
  endtask

  task automatic fset();
    @(negedge clk) frz_set = 1;
    @(negedge clk) frz_set = 0;
  endtask

  task automatic fclr();
    @(negedge clk) frz_clr = 1;
    @(negedge clk) frz_clr = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst = 0;
    cmp_on = 1;
    @(negedge clk);
    check(nmi_o, 0, "R1 nmi after reset");
    check(wrst_o, 0, "R1 wrst after reset");

    // R1: 255 ticks quiet, 256th raises interrupt
    ticks(255);
    check(nmi_o, 0, "R1 no nmi after 255 ticks");
    tick1();
    check(nmi_o, 1, "R1 nmi on tick 256");

    // R2: reload 3
    reload(3);
    check(nmi_o, 0, "R8 reload clears nmi");
    ticks(3);
    check(nmi_o, 0, "R2 no nmi after V ticks");
    tick1();
    check(nmi_o, 1, "R2 nmi on tick V+1");

    // R3: escalation on 15th tick after the interrupt
    ticks(14);
    check(wrst_o, 0, "R3 no reset after 14 ticks");
    tick1();
    check(wrst_o, 1, "R3 reset on 15th tick");
    check(nmi_o, 0, "R5 nmi cleared by reset");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(wrst_o, 1, "R5 reset held");
    end
    @(negedge clk);
    check(wrst_o, 0, "R5 reset released after 4 cycles");
    ticks(255);
    check(nmi_o, 0, "R5 count restarted at 255");
    tick1();
    check(nmi_o, 1, "R5 nmi after 256 ticks from restart");

    // R3: escalation disabled
    cfg(0, 0, 1);
    reload(0);
    tick1();
    check(nmi_o, 1, "R3 nmi with escalation off");
    ticks(40);
    check(wrst_o, 0, "R3 no reset with escalation off");
    check(nmi_o, 1, "R2 nmi held until reload");

    // R4: reset mode
    cfg(1, 1, 1);
    reload(2);
    ticks(2);
    check(wrst_o, 0, "R4 no reset before expiry");
    tick1();
    check(wrst_o, 1, "R4 reset on 0 to -1");
    check(nmi_o, 0, "R4 no nmi in reset mode");
    repeat (5) @(negedge clk);
    cfg(0, 1, 1);

    // R8: reload and tick in the same cycle
    @(negedge clk) begin reload_we = 1; reload_val = 0; tick_en = 1; end
    @(negedge clk) begin reload_we = 0; tick_en = 0; end
    check(nmi_o, 0, "R8 tick discarded during reload");
    tick1();
    check(nmi_o, 1, "R8 count was loaded value");

    // R6: debug halt freezes even when software freeze is disallowed
    cfg(0, 1, 0);
    reload(1);
    @(negedge clk) dbg_halt = 1;
    ticks(10);
    check(nmi_o, 0, "R6 debug halt freezes");
    @(negedge clk) dbg_halt = 0;
    ticks(2);
    check(nmi_o, 1, "R6 counting resumes");

    // R7: software freeze
    cfg(0, 1, 1);
    reload(1);
    fset();
    ticks(10);
    check(nmi_o, 0, "R7 software freeze holds");
    cfg(0, 1, 0);
    ticks(2);
    check(nmi_o, 1, "R7 freeze ignored when disallowed");
    reload(1);
    cfg(0, 1, 1);
    ticks(5);
    check(nmi_o, 0, "R7 kept freeze reapplies");
    @(negedge clk) begin frz_set = 1; frz_clr = 1; end
    @(negedge clk) begin frz_set = 0; frz_clr = 0; end
    ticks(2);
    check(nmi_o, 1, "R7 clear wins over set");

    // random phase checked by the model every cycle
    reload(255);
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      tick_en   = ($urandom_range(0, 1) == 1);
      reload_we = ($urandom_range(0, 39) == 0);
      reload_val = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255))
                                               : 8'($urandom_range(0, 12));
      cfg_we    = ($urandom_range(0, 199) == 0);
      cfg_rst_mode  = ($urandom_range(0, 2) == 0);
      cfg_auto_rst  = ($urandom_range(0, 3) != 0);
      cfg_frz_allow = ($urandom_range(0, 1) == 1);
      frz_set   = ($urandom_range(0, 99) == 0);
      frz_clr   = ($urandom_range(0, 79) == 0);
      if ($urandom_range(0, 149) == 0) dbg_halt = ~dbg_halt;
    end
    @(negedge clk) begin
      tick_en = 0; reload_we = 0; cfg_we = 0; frz_set = 0; frz_clr = 0; dbg_halt = 0;
    end
    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule